// File: doc/BRIEF.md
# Expanded Data RAM Access Router

This block sits between a CPU's external-data load/store path and two possible targets: a small on-chip expanded RAM and an off-chip bus whose low address byte and data share one 8-bit port. A second 8-bit port carries the high address byte. Each request arrives on a valid/ready channel and carries a read/write flag, a mode flag, a 16-bit address and write data. The mode flag selects a 16-bit pointer access or an 8-bit register-indirect access. The block decides where the request goes, runs the access, and returns one response pulse with the read data.

Routing depends on a two-bit auxiliary control register at special-function address 8EH. When the register's RAM-enable bit is clear, every access goes off-chip. When it is set, a pointer access below the on-chip size goes to the RAM, and so does every register-indirect access. Accesses off-chip run a fixed address-latch-enable (ALE) / strobe sequence. While the bus is idle, ALE either toggles freely at a divided rate or stays quiet, depending on the register's ALE-suppress bit.

Handshake rules: `req_ready` is high only when the block is idle. A request is taken on the rising edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the cycle after the response. The response (`rsp_valid`) is a single-cycle pulse with no back-pressure. The requester must be ready to take it.

Top module: `xram_router`

## Requirements
- R1: After reset, the auxiliary register reads 00H, `p2_out` is FFH, `rd_n` and `wr_n` are high, `rsp_valid` is low and `req_ready` is high.
- R2: A special-function write to address 8EH stores bit 1 (RAM enable) and bit 0 (ALE suppress). Reading 8EH returns those bits with bits 7..2 as 0. Writes to any other address leave the register unchanged, and reads of any other address return 00H.
- R3: With RAM enable set, a pointer-mode access (`req_wide`=1) to an address below 0300H uses the on-chip RAM. `rd_n`/`wr_n` stay high, and `rsp_valid` comes one cycle after acceptance with data written earlier.
- R4: With RAM enable set, a pointer-mode access at 0300H or above runs the off-chip sequence.
- R5: With RAM enable set, a register-indirect access (`req_wide`=0) always uses the on-chip RAM. It uses address bits 7..0 only, and these select the same RAM bytes as pointer addresses 0000H..00FFH.
- R6: With RAM enable clear, accesses of both modes run the off-chip sequence, even at addresses below 0300H.
- R7: Off-chip sequence, counted from the acceptance edge:
  - Cycle 1: ALE is high and `p0_out` drives the low address byte with `p0_oe`=1.
  - Cycle 2: ALE is low and the address stays on `p0_out`.
  - Cycles 3 to 2+STROBE_CYC: `wr_n` or `rd_n` is low, and write data is driven on `p0_out`. Read data is taken from `p0_in` in the last strobe cycle.
  - Cycle 3+STROBE_CYC: `rsp_valid` is high.
  - `rd_n` and `wr_n` are never low together.
- R8: An off-chip pointer access puts the high address byte on `p2_out` from cycle 1. An off-chip register-indirect access leaves `p2_out` unchanged.
- R9: With ALE suppress clear and the bus idle, ALE is high for one cycle in every ALE_DIV cycles.
- R10: With ALE suppress set, ALE stays low unless an off-chip access is running. In that case it is high only in that access's address cycle.
- R11: `req_ready` is low from the cycle after acceptance through the response cycle and high in the cycle after. `rsp_valid` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_wr_en | input | 1 | Special-function register write strobe |
| sfr_addr | input | 8 | Special-function register address |
| sfr_wdata | input | 8 | Special-function register write data |
| sfr_rdata | output | 8 | Special-function register read data (combinational) |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit pointer mode, 0 = 8-bit indirect mode |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with `rsp_valid` on reads |
| p0_out | output | 8 | Multiplexed low address / data out |
| p0_oe | output | 1 | Output enable for `p0_out` |
| p0_in | input | 8 | Data in from the multiplexed port |
| p2_out | output | 8 | High address byte / page register |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench drives each request at a falling edge, so acceptance happens on the next rising edge. It then samples every falling edge, counting cycles from that acceptance. An on-chip access must show `rsp_valid` at cycle 1. An off-chip access must show ALE and the address at cycle 1, ALE low at cycle 2, exactly STROBE_CYC strobe cycles from cycle 3, and the response at cycle 3+STROBE_CYC. `req_ready` must be low at every sampled cycle up to the response and high at the cycle after it. Register reads are combinational, and their results are checked in the same cycle as the write edge that precedes them. ALE rate is judged by counting high samples over a whole number of divider periods.

// File: rtl/xr_pkg.sv
package xr_pkg;
  localparam logic [7:0] AUX_SFR_ADDR = 8'h8E;
  localparam int         AUX_RAMEN_BIT = 1;
  localparam int         AUX_ALEQ_BIT  = 0;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_INT   = 3'd1,
    SQ_ADDR  = 3'd2,
    SQ_LATCH = 3'd3,
    SQ_STRB  = 3'd4,
    SQ_DONE  = 3'd5
  } seq_state_e;
endpackage

// File: rtl/xr_auxreg.sv
module xr_auxreg
  import xr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       ram_en,
  output logic       ale_quiet
);
  logic [1:0] aux_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_q <= 2'b00;
    end else if (wr_en && addr == AUX_SFR_ADDR) begin
      aux_q <= {wdata[AUX_RAMEN_BIT], wdata[AUX_ALEQ_BIT]};
    end
  end

  assign ram_en    = aux_q[1];
  assign ale_quiet = aux_q[0];

  always_comb begin
    rdata = 8'h00;
    if (addr == AUX_SFR_ADDR) begin
      rdata[AUX_RAMEN_BIT] = aux_q[1];
      rdata[AUX_ALEQ_BIT]  = aux_q[0];
    end
  end

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[7:2] == 6'd0); // R2
endmodule

// File: rtl/xr_route.sv
module xr_route #(
  parameter int XRAM_BYTES = 768,
  parameter int XA_W       = 10
) (
  input  logic            ram_en,
  input  logic            wide,
  input  logic [15:0]     addr,
  output logic            to_ram,
  output logic [XA_W-1:0] ram_idx
);
  localparam logic [16:0] LIMIT = 17'(XRAM_BYTES);

  always_comb begin
    to_ram  = ram_en && (!wide || ({1'b0, addr} < LIMIT));
    ram_idx = '0;
    if (wide) ram_idx = addr[XA_W-1:0];
    else      ram_idx[7:0] = addr[7:0];
  end
endmodule

// File: rtl/xr_ram.sv
module xr_ram #(
  parameter int DEPTH = 768,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    q
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/xr_bus_seq.sv
module xr_bus_seq
  import xr_pkg::*;
#(
  parameter int STROBE_CYC = 3,
  parameter int ALE_DIV    = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_int,
  input  logic        start_ext,
  input  logic        write,
  input  logic        wide,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic        ale_quiet,
  input  logic [7:0]  p0_in,
  output logic        busy,
  output logic        rsp_valid,
  output logic        int_phase,
  output logic [7:0]  ext_rdata,
  output logic [7:0]  p0_out,
  output logic        p0_oe,
  output logic [7:0]  p2_out,
  output logic        ale,
  output logic        rd_n,
  output logic        wr_n
);
  localparam int SC_W = $clog2(STROBE_CYC + 1);
  localparam int DV_W = $clog2(ALE_DIV + 1);

  seq_state_e      state_q;
  logic [SC_W-1:0] str_cnt;
  logic [DV_W-1:0] div_cnt;
  logic            lat_write;
  logic [7:0]      lat_alo;
  logic [7:0]      lat_wdata;
  logic [7:0]      p2_q;
  logic [7:0]      rd_q;
  logic            ext_active;
  logic            free_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      str_cnt   <= '0;
      lat_write <= 1'b0;
      lat_alo   <= 8'h00;
      lat_wdata <= 8'h00;
      p2_q      <= 8'hFF;
      rd_q      <= 8'h00;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (start_int) begin
            state_q <= SQ_INT;
          end else if (start_ext) begin
            state_q   <= SQ_ADDR;
            lat_write <= write;
            lat_alo   <= addr[7:0];
            lat_wdata <= wdata;
            if (wide) p2_q <= addr[15:8];
          end
        end
        SQ_INT:   state_q <= SQ_IDLE;
        SQ_ADDR:  state_q <= SQ_LATCH;
        SQ_LATCH: begin
          state_q <= SQ_STRB;
          str_cnt <= '0;
        end
        SQ_STRB: begin
          if (str_cnt == SC_W'(STROBE_CYC - 1)) begin
            state_q <= SQ_DONE;
            if (!lat_write) rd_q <= p0_in;
          end else begin
            str_cnt <= str_cnt + 1'b1;
          end
        end
        SQ_DONE:  state_q <= SQ_IDLE;
        default:  state_q <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else if (div_cnt == DV_W'(ALE_DIV - 1)) div_cnt <= '0;
    else div_cnt <= div_cnt + 1'b1;
  end

  assign free_pulse = (div_cnt == DV_W'(ALE_DIV - 1));
  assign ext_active = (state_q == SQ_ADDR) || (state_q == SQ_LATCH) ||
                      (state_q == SQ_STRB) || (state_q == SQ_DONE);

  assign busy      = (state_q != SQ_IDLE);
  assign rsp_valid = (state_q == SQ_INT) || (state_q == SQ_DONE);
  assign int_phase = (state_q == SQ_INT);
  assign ext_rdata = rd_q;
  assign p2_out    = p2_q;
  assign ale       = (state_q == SQ_ADDR) || (!ext_active && !ale_quiet && free_pulse);
  assign rd_n      = !((state_q == SQ_STRB) && !lat_write);
  assign wr_n      = !((state_q == SQ_STRB) && lat_write);

  always_comb begin
    p0_out = 8'h00;
    p0_oe  = 1'b0;
    if (state_q == SQ_ADDR || state_q == SQ_LATCH) begin
      p0_out = lat_alo;
      p0_oe  = 1'b1;
    end else if (state_q == SQ_STRB && lat_write) begin
      p0_out = lat_wdata;
      p0_oe  = 1'b1;
    end
  end

  AST_ALE_THEN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_ADDR) |=> (!ale && p0_oe)); // R7
  AST_STRB_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_STRB) |-> (str_cnt < SC_W'(STROBE_CYC))); // R7
endmodule

// File: rtl/xram_router.sv
module xram_router
  import xr_pkg::*;
#(
  parameter int XRAM_BYTES = 768,
  parameter int STROBE_CYC = 3,
  parameter int ALE_DIV    = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sfr_wr_en,
  input  logic [7:0]  sfr_addr,
  input  logic [7:0]  sfr_wdata,
  output logic [7:0]  sfr_rdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_wide,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        rsp_valid,
  output logic [7:0]  rsp_rdata,
  output logic [7:0]  p0_out,
  output logic        p0_oe,
  input  logic [7:0]  p0_in,
  output logic [7:0]  p2_out,
  output logic        ale,
  output logic        rd_n,
  output logic        wr_n
);
  localparam int XA_W = $clog2(XRAM_BYTES);

  logic            ram_en, ale_quiet, to_ram, accept, busy, int_phase;
  logic [XA_W-1:0] ram_idx;
  logic [7:0]      ram_q, ext_rdata;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  xr_auxreg u_aux (
    .clk(clk), .rst_n(rst_n), .wr_en(sfr_wr_en), .addr(sfr_addr),
    .wdata(sfr_wdata), .rdata(sfr_rdata), .ram_en(ram_en), .ale_quiet(ale_quiet)
  );

  xr_route #(.XRAM_BYTES(XRAM_BYTES), .XA_W(XA_W)) u_route (
    .ram_en(ram_en), .wide(req_wide), .addr(req_addr),
    .to_ram(to_ram), .ram_idx(ram_idx)
  );

  xr_ram #(.DEPTH(XRAM_BYTES), .AW(XA_W)) u_ram (
    .clk(clk), .we(accept && to_ram && req_write),
    .re(accept && to_ram && !req_write), .addr(ram_idx),
    .wdata(req_wdata), .q(ram_q)
  );

  xr_bus_seq #(.STROBE_CYC(STROBE_CYC), .ALE_DIV(ALE_DIV)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_int(accept && to_ram), .start_ext(accept && !to_ram),
    .write(req_write), .wide(req_wide), .addr(req_addr), .wdata(req_wdata),
    .ale_quiet(ale_quiet), .p0_in(p0_in), .busy(busy), .rsp_valid(rsp_valid),
    .int_phase(int_phase), .ext_rdata(ext_rdata), .p0_out(p0_out),
    .p0_oe(p0_oe), .p2_out(p2_out), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  assign rsp_rdata = int_phase ? ram_q : ext_rdata;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R7
  AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    int_phase |-> (rd_n && wr_n)); // R3
  AST_P2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !to_ram && !req_wide) |=> $stable(p2_out)); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11
  AST_NO_READY_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R11
endmodule

// File: tb/xram_router_tb.sv
module xram_router_tb;
  localparam int SC  = 3;
  localparam int DIV = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sfr_wr_en = 0; logic [7:0] sfr_addr = 0, sfr_wdata = 0, sfr_rdata;
  logic req_valid = 0, req_ready, req_write = 0, req_wide = 0;
  logic [15:0] req_addr = 0; logic [7:0] req_wdata = 0;
  logic rsp_valid; logic [7:0] rsp_rdata;
  logic [7:0] p0_out, p2_out, p0_in = 8'h3C; logic p0_oe, ale, rd_n, wr_n;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xram_router #(.XRAM_BYTES(768), .STROBE_CYC(SC), .ALE_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_wr_en(sfr_wr_en), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in),
    .p2_out(p2_out), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sfr_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    sfr_wr_en = 1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_wr_en = 0;
  endtask

  // observation record of one access
  int lat, n_rd, n_wr, n_ale, ale1, ale2, oe1, p0a1, p0a2, p2a1, wseen, rdat;
  bit ready_bad;

  task automatic access(bit wr, bit wide, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_wide = wide; req_addr = a; req_wdata = d;
    lat = -1; n_rd = 0; n_wr = 0; n_ale = 0; wseen = -1; rdat = -1;
    ready_bad = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      req_valid = 0;
      if (req_ready) ready_bad = 1;
      if (ale) n_ale++;
      if (!rd_n) n_rd++;
      if (!wr_n) begin n_wr++; wseen = p0_out; end
      if (i == 1) begin ale1 = ale; oe1 = p0_oe; p0a1 = p0_out; p2a1 = p2_out; end
      if (i == 2) begin ale2 = ale; p0a2 = p0_out; end
      if (rsp_valid) begin lat = i; rdat = rsp_rdata; break; end
    end
    @(negedge clk);
    chk("R11", "ready low until response", ready_bad, 0);
    chk("R11", "ready after response", req_ready, 1);
    chk("R11", "response one cycle", rsp_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1", "aux reset", sfr_rdata, 8'h00);
    chk("R1", "p2 reset", p2_out, 8'hFF);
    chk("R1", "strobes idle", {rd_n, wr_n}, 2'b11);
    chk("R1", "rsp idle", rsp_valid, 0);
    chk("R1", "ready idle", req_ready, 1);
  endtask

  task automatic t_sfr();
    sfr_write(8'h8E, 8'hFF);
    sfr_addr = 8'h8E; #1;
    chk("R2", "reserved bits read 0", sfr_rdata, 8'h03);
    sfr_write(8'h8F, 8'h00);
    sfr_addr = 8'h8E; #1;
    chk("R2", "other address ignored", sfr_rdata, 8'h03);
    sfr_addr = 8'h8F; #1;
    chk("R2", "other address reads 0", sfr_rdata, 8'h00);
    sfr_write(8'h8E, 8'h00);
  endtask

  task automatic t_ext_off();
    access(1, 1, 16'h1234, 8'hA5);
    chk("R6", "latency ext write", lat, 3 + SC);
    chk("R7", "ale cycle1", ale1, 1);
    chk("R7", "p0 addr cycle1", p0a1, 8'h34);
    chk("R7", "p0 oe cycle1", oe1, 1);
    chk("R8", "p2 high byte", p2a1, 8'h12);
    chk("R7", "ale low cycle2", ale2, 0);
    chk("R7", "p0 addr cycle2", p0a2, 8'h34);
    chk("R7", "wr strobe cycles", n_wr, SC);
    chk("R7", "no rd on write", n_rd, 0);
    chk("R7", "write data", wseen, 8'hA5);
    access(0, 1, 16'h0100, 8'h00);
    chk("R6", "low addr still off-chip", lat, 3 + SC);
    chk("R7", "rd strobe cycles", n_rd, SC);
    chk("R7", "read data", rdat, 8'h3C);
    access(0, 0, 16'h5577, 8'h00);
    chk("R6", "indirect off-chip", lat, 3 + SC);
    chk("R8", "p2 unchanged indirect", p2a1, 8'h01);
    chk("R8", "p0 low byte indirect", p0a1, 8'h77);
  endtask

  task automatic t_internal();
    sfr_write(8'h8E, 8'h03);
    access(1, 1, 16'h02FF, 8'h5A);
    chk("R3", "int write latency", lat, 1);
    chk("R3", "int no strobes", n_rd + n_wr, 0);
    chk("R10", "no ale int", n_ale, 0);
    access(0, 1, 16'h02FF, 8'h00);
    chk("R3", "int readback top byte", rdat, 8'h5A);
    chk("R3", "int read no strobe", n_rd, 0);
    access(1, 1, 16'h0055, 8'hC3);
    access(0, 0, 16'hAB55, 8'h00);
    chk("R5", "indirect latency", lat, 1);
    chk("R5", "indirect shares low bytes", rdat, 8'hC3);
    access(1, 0, 16'hFF10, 8'h77);
    chk("R5", "indirect write no strobe", n_wr, 0);
    access(0, 1, 16'h0010, 8'h00);
    chk("R5", "indirect write seen by pointer", rdat, 8'h77);
    access(1, 1, 16'h0300, 8'h99);
    chk("R4", "boundary off-chip latency", lat, 3 + SC);
    chk("R4", "boundary wr strobes", n_wr, SC);
    chk("R10", "ale once in ext access", n_ale, 1);
  endtask

  task automatic t_ale();
    int cnt, pairs, prev;
    sfr_write(8'h8E, 8'h01);
    cnt = 0;
    for (int i = 0; i < 6 * DIV; i++) begin @(negedge clk); if (ale) cnt++; end
    chk("R10", "ale quiet idle", cnt, 0);
    sfr_write(8'h8E, 8'h00);
    cnt = 0; pairs = 0; prev = 0;
    for (int i = 0; i < 6 * DIV; i++) begin
      @(negedge clk);
      if (ale) cnt++;
      if (ale && prev != 0) pairs++;
      prev = ale;
    end
    chk("R9", "free ale count", cnt, 6);
    chk("R9", "free ale one cycle wide", pairs, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    sfr_addr = 8'h8E; #1;
    t_reset();
    rst_n = 1;
    t_sfr();
    t_ext_off();
    t_internal();
    t_ale();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule